// File: doc/BRIEF.md
# Sub-frame Splitter

The splitter takes a byte stream of SuperPackets on a single-region word bus. Each SuperPacket holds one or more sub-frames packed back to back. It sends every sub-frame out as a packet of its own, with its own start and end markers. A sub-frame opens with a header of `HDR_BYTES` bytes. The first two header bytes hold the payload length as a little-endian count of bytes, and that count does not include the header. Every sub-frame begins on an 8-byte block boundary, so a small alignment gap can sit between one sub-frame and the next. A gap of up to seven bytes can also follow the last sub-frame before the SuperPacket's end marker.

Output words keep the input byte layout. The splitter does not shift any data. It repeats an input word once for each sub-frame whose payload reaches into it. The start byte it reports points just past the header, so the header never counts as part of the packet. The header bytes, together with a tag sampled at the SuperPacket start, go out as metadata. A mode parameter chooses where: on the first beat, on the last beat, or on a separate header output that pulses with the first beat. A stalled output holds the whole pipeline, and nothing is lost.

Top module: `subframe_splitter`

## Requirements
- R1: During reset and on the first cycle after it, `out_valid` and `hdr_valid` are 0.
- R2: For a sub-frame that starts at byte offset p, the length L is header byte 0 plus 256 times header byte 1. The payload spans offsets p+HDR_BYTES through p+HDR_BYTES+L-1. `out_sof_byte` and `out_eof_byte` give the byte index of those two offsets within the word that carries each one. A position field reads 0 on any beat where its flag is low.
- R3: The next sub-frame starts at the end offset plus one, rounded up to a multiple of 8.
- R4: For each sub-frame, in order, one output beat is issued for every input word that holds part of its payload. `out_data` is that input word unchanged.
- R5: If the SuperPacket end marker lies up to 7 bytes past the end of the last sub-frame, no extra sub-frame is produced, and the next SuperPacket comes out correctly.
- R6: At most `MAX_SUB` sub-frames are emitted per SuperPacket. Any later sub-frames are dropped, and the next SuperPacket is not affected.
- R7: With `META_MODE`=0, `out_meta` = {tag, header} on the start beat and 0 on every other beat. Header byte i occupies bits [8i+7:8i], and the tag sits above the header bytes.
- R8: With `META_MODE`=1, `out_meta` carries the same value on the end beat only.
- R9: With `META_MODE`=2, `out_meta` is 0. `hdr_valid` is high exactly with the start beat, and `hdr_data` then carries {tag, header}.
- R10: A sub-frame whose payload runs past the SuperPacket end is cut there. Its end beat carries `out_eof_byte` equal to the input end byte, with `out_err` high. `out_err` is never high off an end beat.
- R11: While `out_valid` is high and `out_ready` is low, every output stays unchanged.
- R12: Input words that arrive outside a SuperPacket and carry no start marker produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | BLOCKS*64 | Input word, byte i at bits [8i+7:8i] |
| in_sof | input | 1 | SuperPacket starts in this word |
| in_sof_blk | input | max(1,log2 BLOCKS) | Block index of the SuperPacket start |
| in_eof | input | 1 | SuperPacket ends in this word |
| in_eof_byte | input | log2(BLOCKS*8) | Byte index of the last SuperPacket byte |
| in_tag | input | TAG_W | SuperPacket tag, sampled with the start |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted at this edge |
| out_data | output | BLOCKS*64 | Output word |
| out_sof | output | 1 | Sub-frame payload starts in this beat |
| out_sof_byte | output | log2(BLOCKS*8) | Byte index of the first payload byte |
| out_eof | output | 1 | Sub-frame payload ends in this beat |
| out_eof_byte | output | log2(BLOCKS*8) | Byte index of the last payload byte |
| out_err | output | 1 | Sub-frame cut short at the SuperPacket end |
| out_meta | output | TAG_W+HDR_BYTES*8 | Tag and header for modes 0 and 1 |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| hdr_data | output | TAG_W+HDR_BYTES*8 | Tag and header for mode 2 |
| hdr_valid | output | 1 | Header output valid (mode 2) |

## Verification
The assertions and the position arithmetic assume well-formed input. Every length field is at least 1. Each SuperPacket fits within `MTU` bytes. The end marker of a SuperPacket never comes before the first payload byte of its last sub-frame. A new start marker arrives only once the previous SuperPacket has ended. The stimulus builds every SuperPacket from a list of sub-frame lengths, which keeps all of these conditions true. It draws the pad after the last sub-frame no larger than that sub-frame's alignment gap. When it cuts a SuperPacket short, it cuts strictly inside the last payload. It sends stray words only between SuperPackets.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  // metadata placement selector values
  localparam int MODE_AT_SOF = 0;
  localparam int MODE_AT_EOF = 1;
  localparam int MODE_SIDE   = 2;

  // round a byte offset up to the next 8-byte block boundary
  function automatic logic [31:0] blk_ceil(input logic [31:0] x);
    return (x + 32'd7) & ~32'd7;
  endfunction

  // little-endian 16-bit length from two header bytes
  function automatic logic [15:0] le_len(input logic [7:0] b0, input logic [7:0] b1);
    return {b1, b0};
  endfunction
endpackage

// File: rtl/sfs_hdr_grab.sv
module sfs_hdr_grab #(
  parameter int WB        = 32,
  parameter int HDR_BYTES = 12,
  parameter int POSW      = 14
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [WB*8-1:0]        data,
  input  logic [POSW-1:0]        base,
  input  logic [POSW-1:0]        start,
  output logic [HDR_BYTES*8-1:0] hdr_next,
  output logic                   hdr_done,
  output logic [15:0]            len
);
  import sfs_pkg::*;
  localparam int PW = $clog2(WB);

  logic [HDR_BYTES*8-1:0] hdr_q;

  // each header byte is taken from this word when its offset falls inside it
  for (genvar i = 0; i < HDR_BYTES; i++) begin : g_byte
    logic [POSW-1:0] abs_pos;
    logic [PW-1:0]   idx;
    logic            here;
    assign abs_pos = start + POSW'(i);
    assign here    = (abs_pos >= base) && (abs_pos < base + POSW'(WB));
    assign idx     = PW'(abs_pos - base);
    assign hdr_next[i*8 +: 8] = here ? data[{idx, 3'b000} +: 8] : hdr_q[i*8 +: 8];
  end

  assign hdr_done = (start + POSW'(HDR_BYTES)) <= (base + POSW'(WB));
  assign len      = le_len(hdr_next[7:0], hdr_next[15:8]);

  always_ff @(posedge clk) begin
    if (rst)       hdr_q <= '0;
    else if (load) hdr_q <= hdr_next;
  end
endmodule

// File: rtl/sfs_span_calc.sv
module sfs_span_calc #(
  parameter int WB        = 32,
  parameter int HDR_BYTES = 12,
  parameter int POSW      = 14
) (
  input  logic [POSW-1:0]       start,
  input  logic [POSW-1:0]       base,
  input  logic [15:0]           len,
  input  logic                  hdr_done,
  input  logic                  eof,
  input  logic [$clog2(WB)-1:0] eof_byte,
  output logic                  pay_here,
  output logic                  sof_here,
  output logic [$clog2(WB)-1:0] sof_byte,
  output logic                  ends_here,
  output logic [$clog2(WB)-1:0] end_byte,
  output logic                  cut,
  output logic                  nxt_past_end,
  output logic                  nxt_in_word,
  output logic [POSW-1:0]       nxt
);
  import sfs_pkg::*;
  localparam int PW = $clog2(WB);

  logic [POSW-1:0] pay_s, pay_e, limit, sp_end;
  logic            no_payload;

  assign pay_s  = start + POSW'(HDR_BYTES);
  assign pay_e  = pay_s + POSW'(len) - POSW'(1);
  assign limit  = base + POSW'(WB);
  assign sp_end = base + POSW'(eof_byte);

  // SuperPacket ends before this sub-frame has any payload byte
  assign no_payload = eof && (pay_s > sp_end);
  assign pay_here   = hdr_done && (pay_s < limit) && !no_payload;
  assign sof_here   = pay_s >= base;
  assign sof_byte   = sof_here ? PW'(pay_s - base) : '0;
  assign cut        = eof && (pay_e > sp_end);
  assign ends_here  = cut || (pay_e < limit);
  assign end_byte   = !ends_here ? '0 : (cut ? eof_byte : PW'(pay_e - base));

  assign nxt          = POSW'(blk_ceil(32'(pay_e) + 32'd1));
  assign nxt_past_end = eof && (nxt > sp_end);
  assign nxt_in_word  = nxt < limit;
endmodule

// File: rtl/sfs_out_reg.sv
module sfs_out_reg #(
  parameter int DW    = 256,
  parameter int PW    = 5,
  parameter int MW    = 104,
  parameter int MODE  = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          take,
  input  logic          emit,
  input  logic [DW-1:0] d,
  input  logic          sof,
  input  logic [PW-1:0] sof_b,
  input  logic          eof,
  input  logic [PW-1:0] eof_b,
  input  logic          err,
  input  logic [MW-1:0] full,
  output logic          vq,
  output logic [DW-1:0] d_q,
  output logic          sof_q,
  output logic [PW-1:0] sof_b_q,
  output logic          eof_q,
  output logic [PW-1:0] eof_b_q,
  output logic          err_q,
  output logic [MW-1:0] meta_q,
  output logic [MW-1:0] side_q,
  output logic          side_v
);
  import sfs_pkg::*;

  logic [MW-1:0] meta_d, side_d;
  logic          side_flag_d, side_flag_q;

  if (MODE == MODE_AT_SOF) begin : g_sof
    assign meta_d = sof ? full : '0;
    assign side_d = '0;
    assign side_flag_d = 1'b0;
  end else if (MODE == MODE_AT_EOF) begin : g_eof
    assign meta_d = eof ? full : '0;
    assign side_d = '0;
    assign side_flag_d = 1'b0;
  end else begin : g_side
    assign meta_d = '0;
    assign side_d = sof ? full : '0;
    assign side_flag_d = sof;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vq <= 1'b0; d_q <= '0; sof_q <= 1'b0; sof_b_q <= '0; eof_q <= 1'b0;
      eof_b_q <= '0; err_q <= 1'b0; meta_q <= '0; side_q <= '0; side_flag_q <= 1'b0;
    end else if (load) begin
      vq <= emit;
      d_q <= d; sof_q <= sof; sof_b_q <= sof_b; eof_q <= eof; eof_b_q <= eof_b;
      err_q <= err; meta_q <= meta_d; side_q <= side_d; side_flag_q <= side_flag_d;
    end else if (take) begin
      vq <= 1'b0;
    end
  end

  assign side_v = vq && side_flag_q;

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (vq && !take) |=> (vq && $stable(d_q) && $stable(sof_q) && $stable(eof_q)
                       && $stable(sof_b_q) && $stable(eof_b_q) && $stable(meta_q)));

  assert_err_on_end_R10: assert property (@(posedge clk) disable iff (rst)
    (vq && err_q) |-> eof_q);

  assert_positions_ordered_R2: assert property (@(posedge clk) disable iff (rst)
    (vq && sof_q && eof_q) |-> (sof_b_q <= eof_b_q));
endmodule

// File: rtl/subframe_splitter.sv
module subframe_splitter #(
  parameter int BLOCKS    = 4,
  parameter int HDR_BYTES = 12,
  parameter int TAG_W     = 8,
  parameter int MAX_SUB   = 4,
  parameter int META_MODE = 0,
  parameter int MTU       = 2048
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic [BLOCKS*64-1:0]                      in_data,
  input  logic                                      in_sof,
  input  logic [((BLOCKS > 1) ? $clog2(BLOCKS) : 1)-1:0] in_sof_blk,
  input  logic                                      in_eof,
  input  logic [$clog2(BLOCKS*8)-1:0]               in_eof_byte,
  input  logic [TAG_W-1:0]                          in_tag,
  input  logic                                      in_valid,
  output logic                                      in_ready,
  output logic [BLOCKS*64-1:0]                      out_data,
  output logic                                      out_sof,
  output logic [$clog2(BLOCKS*8)-1:0]               out_sof_byte,
  output logic                                      out_eof,
  output logic [$clog2(BLOCKS*8)-1:0]               out_eof_byte,
  output logic                                      out_err,
  output logic [TAG_W+HDR_BYTES*8-1:0]              out_meta,
  output logic                                      out_valid,
  input  logic                                      out_ready,
  output logic [TAG_W+HDR_BYTES*8-1:0]              hdr_data,
  output logic                                      hdr_valid
);
  localparam int WB   = BLOCKS * 8;
  localparam int DW   = WB * 8;
  localparam int PW   = $clog2(WB);
  localparam int BW   = (BLOCKS > 1) ? $clog2(BLOCKS) : 1;
  localparam int POSW = $clog2(MTU) + 3;
  localparam int MW   = TAG_W + HDR_BYTES * 8;
  localparam int CW   = $clog2(MAX_SUB + 1);

  // SuperPacket-level state
  logic             in_sp_q, drop_q;
  logic [POSW-1:0]  base_q, p_q;
  logic [CW-1:0]    cnt_q;
  logic [TAG_W-1:0] tag_q;

  logic             in_sp_n, drop_n, consume;
  logic [POSW-1:0]  base_n, p_n;
  logic [CW-1:0]    cnt_n;
  logic [TAG_W-1:0] tag_n;

  // events brought out for the checks
  logic             active, dropping, advance, step, emit, sub_done, hold_word;
  logic [POSW-1:0]  base_e, p_e, sp_end;
  logic [CW-1:0]    cnt_e;
  logic [TAG_W-1:0] tag_e;

  logic [HDR_BYTES*8-1:0] hdr_next;
  logic                   hdr_done;
  logic [15:0]            len;
  logic                   pay_here, sof_here, ends_here, cut, nxt_past_end, nxt_in_word;
  logic [PW-1:0]          sof_byte, end_byte;
  logic [POSW-1:0]        nxt;
  logic                   vq;

  assign active   = in_sp_q || in_sof;
  assign dropping = in_sp_q && drop_q;
  assign base_e   = in_sp_q ? base_q : '0;
  assign p_e      = in_sp_q ? p_q : POSW'({in_sof_blk, 3'b000});
  assign cnt_e    = in_sp_q ? cnt_q : '0;
  assign tag_e    = in_sp_q ? tag_q : in_tag;
  assign sp_end   = base_e + POSW'(in_eof_byte);

  sfs_hdr_grab #(.WB(WB), .HDR_BYTES(HDR_BYTES), .POSW(POSW)) i_grab (
    .clk(clk), .rst(rst), .load(step), .data(in_data), .base(base_e), .start(p_e),
    .hdr_next(hdr_next), .hdr_done(hdr_done), .len(len));

  sfs_span_calc #(.WB(WB), .HDR_BYTES(HDR_BYTES), .POSW(POSW)) i_span (
    .start(p_e), .base(base_e), .len(len), .hdr_done(hdr_done), .eof(in_eof),
    .eof_byte(in_eof_byte), .pay_here(pay_here), .sof_here(sof_here), .sof_byte(sof_byte),
    .ends_here(ends_here), .end_byte(end_byte), .cut(cut), .nxt_past_end(nxt_past_end),
    .nxt_in_word(nxt_in_word), .nxt(nxt));

  assign advance   = !vq || out_ready;
  assign step      = in_valid && advance;
  assign emit      = active && !dropping && pay_here;
  assign sub_done  = emit && ends_here;
  assign hold_word = !consume;
  assign in_ready  = advance && consume;

  always_comb begin
    consume = 1'b1;
    in_sp_n = in_sp_q; drop_n = drop_q; base_n = base_q; p_n = p_q;
    cnt_n = cnt_q; tag_n = tag_q;
    if (active) begin
      if (!in_sp_q) begin
        in_sp_n = 1'b1; drop_n = 1'b0; cnt_n = '0; tag_n = in_tag;
        base_n = '0; p_n = p_e;
      end
      if (dropping) begin
        if (in_eof) in_sp_n = 1'b0;
        else        base_n = base_e + POSW'(WB);
      end else if (sub_done) begin
        cnt_n = cnt_e + CW'(1);
        if (in_eof && (cut || nxt_past_end)) begin
          in_sp_n = 1'b0;
        end else if (cnt_e + CW'(1) == CW'(MAX_SUB)) begin
          if (in_eof) in_sp_n = 1'b0;
          else begin drop_n = 1'b1; base_n = base_e + POSW'(WB); end
        end else if (nxt_in_word) begin
          consume = 1'b0;
          p_n = nxt;
        end else begin
          p_n = nxt;
          base_n = base_e + POSW'(WB);
        end
      end else begin
        base_n = base_e + POSW'(WB);
        if (in_eof) in_sp_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_sp_q <= 1'b0; drop_q <= 1'b0; base_q <= '0; p_q <= '0;
      cnt_q <= '0; tag_q <= '0;
    end else if (step) begin
      in_sp_q <= in_sp_n; drop_q <= drop_n; base_q <= base_n; p_q <= p_n;
      cnt_q <= cnt_n; tag_q <= tag_n;
    end
  end

  sfs_out_reg #(.DW(DW), .PW(PW), .MW(MW), .MODE(META_MODE)) i_out (
    .clk(clk), .rst(rst), .load(step), .take(out_ready), .emit(emit),
    .d(in_data), .sof(emit && sof_here), .sof_b(sof_byte), .eof(sub_done),
    .eof_b(end_byte), .err(sub_done && cut), .full({tag_e, hdr_next}),
    .vq(vq), .d_q(out_data), .sof_q(out_sof), .sof_b_q(out_sof_byte),
    .eof_q(out_eof), .eof_b_q(out_eof_byte), .err_q(out_err), .meta_q(out_meta),
    .side_q(hdr_data), .side_v(hdr_valid));

  assign out_valid = vq;

  // a held word always moves on to a block-aligned start
  assert_next_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    (step && hold_word) |=> (p_q[2:0] == 3'b000));

  // the sub-frame count never passes the cap while emitting
  assert_cap_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (in_sp_q && !drop_q) |-> (cnt_q < CW'(MAX_SUB)));
endmodule

// File: tb/test_subframe_splitter.sv
module test_subframe_splitter;
  localparam int CLK_PERIOD = 10;
  localparam int BLOCKS = 4, HDR = 12, TAG_W = 8, MAX_SUB = 4, MTU = 2048;
  localparam int WB = BLOCKS * 8, DW = WB * 8, PW = $clog2(WB), MW = TAG_W + HDR * 8;

  logic clk = 0, rst = 1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [DW-1:0] in_data = '0;
  logic in_sof = 0, in_eof = 0, in_valid = 0, out_ready = 0;
  logic [1:0] in_sof_blk = '0;
  logic [PW-1:0] in_eof_byte = '0;
  logic [TAG_W-1:0] in_tag = '0;

  logic in_ready, rdy1, rdy2;
  logic [DW-1:0] od0, od1, od2;
  logic s0, s1, s2, e0, e1, e2, er0, er1, er2, v0, v1, v2, hv0, hv1, hv2;
  logic [PW-1:0] sb0, sb1, sb2, eb0, eb1, eb2;
  logic [MW-1:0] m0, m1, m2, h0, h1, h2;

  subframe_splitter #(.META_MODE(0)) i_subframe_splitter (
    .clk(clk), .rst(rst), .in_data(in_data), .in_sof(in_sof), .in_sof_blk(in_sof_blk),
    .in_eof(in_eof), .in_eof_byte(in_eof_byte), .in_tag(in_tag), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(od0), .out_sof(s0), .out_sof_byte(sb0), .out_eof(e0),
    .out_eof_byte(eb0), .out_err(er0), .out_meta(m0), .out_valid(v0), .out_ready(out_ready),
    .hdr_data(h0), .hdr_valid(hv0));
  subframe_splitter #(.META_MODE(1)) i_subframe_splitter_m1 (
    .clk(clk), .rst(rst), .in_data(in_data), .in_sof(in_sof), .in_sof_blk(in_sof_blk),
    .in_eof(in_eof), .in_eof_byte(in_eof_byte), .in_tag(in_tag), .in_valid(in_valid),
    .in_ready(rdy1), .out_data(od1), .out_sof(s1), .out_sof_byte(sb1), .out_eof(e1),
    .out_eof_byte(eb1), .out_err(er1), .out_meta(m1), .out_valid(v1), .out_ready(out_ready),
    .hdr_data(h1), .hdr_valid(hv1));
  subframe_splitter #(.META_MODE(2)) i_subframe_splitter_m2 (
    .clk(clk), .rst(rst), .in_data(in_data), .in_sof(in_sof), .in_sof_blk(in_sof_blk),
    .in_eof(in_eof), .in_eof_byte(in_eof_byte), .in_tag(in_tag), .in_valid(in_valid),
    .in_ready(rdy2), .out_data(od2), .out_sof(s2), .out_sof_byte(sb2), .out_eof(e2),
    .out_eof_byte(eb2), .out_err(er2), .out_meta(m2), .out_valid(v2), .out_ready(out_ready),
    .hdr_data(h2), .hdr_valid(hv2));

  typedef struct { logic [DW-1:0] d; bit sof; int sblk; bit eof; int eb; logic [7:0] tag; } ib_t;
  typedef struct { logic [DW-1:0] d; bit sof; int sb; bit eof; int eb; bit err;
                   bit later; logic [MW-1:0] full; string rq; } eb_t;
  ib_t ib[0:4095];
  eb_t ex[0:8191];
  int n_ib = 0, n_ex = 0, checks = 0, errors = 0;
  byte unsigned spb[0:2047];

  task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic int ceil8(input int x);
    return ((x + 7) / 8) * 8;
  endfunction

  // build one SuperPacket, queue its input words and expected beats
  task automatic build_sp(input logic [7:0] tag, input int s0b, input int n, input int lens[8],
                          input int pad, input int cut_back, input string rq);
    int p, a[8], e[8], gap, spend, nrec;
    logic [MW-1:0] fh[8];
    for (int k = 0; k < 2048; k++) spb[k] = 8'($urandom);
    p = s0b * 8;
    for (int j = 0; j < n; j++) begin
      spb[p] = 8'(lens[j] & 255);
      spb[p + 1] = 8'(lens[j] >> 8);
      fh[j] = '0;
      for (int i = 0; i < HDR; i++) fh[j][i*8 +: 8] = spb[p + i];
      fh[j][MW-1 -: TAG_W] = tag;
      a[j] = p + HDR;
      e[j] = a[j] + lens[j] - 1;
      p = ceil8(e[j] + 1);
    end
    gap = p - (e[n-1] + 1);
    spend = e[n-1] + ((pad > gap) ? gap : pad);
    if (cut_back > 0) begin spend = e[n-1] - cut_back; e[n-1] = spend; end
    for (int w = 0; w <= spend / WB; w++) begin
      for (int b = 0; b < WB; b++) ib[n_ib].d[b*8 +: 8] = spb[w*WB + b];
      ib[n_ib].sof = (w == 0); ib[n_ib].sblk = s0b; ib[n_ib].eof = (w == spend / WB);
      ib[n_ib].eb = spend % WB; ib[n_ib].tag = tag;
      n_ib++;
    end
    nrec = (n < MAX_SUB) ? n : MAX_SUB;
    for (int j = 0; j < nrec; j++)
      for (int w = a[j] / WB; w <= e[j] / WB; w++) begin
        for (int b = 0; b < WB; b++) ex[n_ex].d[b*8 +: 8] = spb[w*WB + b];
        ex[n_ex].sof = (w == a[j] / WB); ex[n_ex].sb = ex[n_ex].sof ? a[j] % WB : 0;
        ex[n_ex].eof = (w == e[j] / WB); ex[n_ex].eb = ex[n_ex].eof ? e[j] % WB : 0;
        ex[n_ex].err = ex[n_ex].eof && (cut_back > 0) && (j == n - 1);
        ex[n_ex].later = (j > 0); ex[n_ex].full = fh[j]; ex[n_ex].rq = rq;
        n_ex++;
      end
  endtask

  task automatic junk(input int k);
    for (int i = 0; i < k; i++) begin
      for (int b = 0; b < BLOCKS * 2; b++) ib[n_ib].d[b*32 +: 32] = $urandom;
      ib[n_ib].sof = 0; ib[n_ib].sblk = 0; ib[n_ib].eof = 1'($urandom); ib[n_ib].eb = 5;
      ib[n_ib].tag = 8'hEE;
      n_ib++;
    end
  endtask

  // compare one accepted beat of all three instances with the expectation
  task automatic cmp_beat(input eb_t x);
    logic [MW-1:0] zero = '0;
    chk(od0 == x.d && od1 == x.d && od2 == x.d, {x.rq, " R4 data"}, od0, x.d);
    chk(s0 == x.sof && s1 == x.sof && s2 == x.sof, x.later ? "R3 sof" : "R2 sof", DW'(s0), DW'(x.sof));
    chk(int'(sb0) == x.sb && sb1 == sb0 && sb2 == sb0, x.later ? "R3 sof byte" : "R2 sof byte",
        DW'(sb0), DW'(x.sb));
    chk(e0 == x.eof && e1 == x.eof && e2 == x.eof, "R2 eof", DW'(e0), DW'(x.eof));
    chk(int'(eb0) == x.eb && eb1 == eb0 && eb2 == eb0, x.err ? "R10 eof byte" : "R2 eof byte",
        DW'(eb0), DW'(x.eb));
    chk(er0 == x.err && er1 == x.err && er2 == x.err, "R10 err", DW'(er0), DW'(x.err));
    chk(m0 == (x.sof ? x.full : zero), "R7 meta at start", DW'(m0), DW'(x.sof ? x.full : zero));
    chk(m1 == (x.eof ? x.full : zero), "R8 meta at end", DW'(m1), DW'(x.eof ? x.full : zero));
    chk(m2 == zero && hv2 == x.sof && (!x.sof || h2 == x.full), "R9 side header",
        DW'(h2), DW'(x.sof ? x.full : zero));
    chk(hv0 == 0 && hv1 == 0, "R9 side idle in modes 0/1", DW'({hv0, hv1}), '0);
  endtask

  int idx_in = 0, idx_out = 0, cyc = 0;
  bit stalled = 0, ready_bias = 1;
  logic [DW-1:0] sv_d;
  logic [MW-1:0] sv_m;
  logic [PW-1:0] sv_sb, sv_eb;
  logic sv_s, sv_e;

  task automatic run(input int limit);
    while ((idx_in < n_ib || idx_out < n_ex) && cyc < limit) begin
      @(negedge clk);
      cyc++;
      out_ready = ready_bias ? 1'b1 : ($urandom % 4 != 0);
      if (idx_in < n_ib) begin
        in_valid = ($urandom % 8 != 0);
        in_data = ib[idx_in].d; in_sof = ib[idx_in].sof; in_sof_blk = 2'(ib[idx_in].sblk);
        in_eof = ib[idx_in].eof; in_eof_byte = PW'(ib[idx_in].eb); in_tag = ib[idx_in].tag;
      end else in_valid = 0;
      #1;
      if (stalled)
        chk(v0 && od0 == sv_d && m0 == sv_m && s0 == sv_s && e0 == sv_e && sb0 == sv_sb
            && eb0 == sv_eb, "R11 stall hold", od0, sv_d);
      if (v0 && out_ready) begin
        if (idx_out < n_ex) cmp_beat(ex[idx_out]);
        else chk(0, "R12 extra beat", DW'(v0), '0);
        idx_out++;
      end
      stalled = v0 && !out_ready;
      sv_d = od0; sv_m = m0; sv_s = s0; sv_e = e0; sv_sb = sb0; sv_eb = eb0;
      if (in_valid && in_ready) idx_in++;
    end
  endtask

  initial begin
    int lens[8];
    int watchdog_hit;
    watchdog_hit = 0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    #1;
    chk(v0 == 0 && hv2 == 0, "R1 in reset", DW'({v0, hv2}), '0);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    #1;
    chk(v0 == 0 && v1 == 0 && v2 == 0 && hv2 == 0, "R1 after reset", DW'({v0, v1, v2, hv2}), '0);

    // directed cases
    lens = '{1, 2, 3, 0, 0, 0, 0, 0};       build_sp(8'h11, 0, 3, lens, 1, 0, "R3");
    lens = '{20, 8, 0, 0, 0, 0, 0, 0};      build_sp(8'h22, 3, 2, lens, 7, 0, "R5");
    lens = '{20, 0, 0, 0, 0, 0, 0, 0};      build_sp(8'h33, 0, 1, lens, 0, 0, "R5");
    lens = '{300, 0, 0, 0, 0, 0, 0, 0};     build_sp(8'h44, 1, 1, lens, 3, 0, "R2");
    lens = '{5, 5, 5, 5, 5, 5, 0, 0};       build_sp(8'h55, 0, 6, lens, 2, 0, "R6");
    lens = '{10, 0, 0, 0, 0, 0, 0, 0};      build_sp(8'h66, 2, 1, lens, 0, 0, "R6");
    lens = '{30, 40, 0, 0, 0, 0, 0, 0};     build_sp(8'h77, 0, 2, lens, 0, 10, "R10");
    junk(3);
    lens = '{9, 0, 0, 0, 0, 0, 0, 0};       build_sp(8'h88, 1, 1, lens, 0, 0, "R12");
    run(20000);

    // random phase with backpressure
    ready_bias = 0;
    for (int s = 0; s < 40; s++) begin
      int n;
      n = 1 + ($urandom % 5);
      for (int j = 0; j < 8; j++) lens[j] = 1 + ($urandom % (($urandom % 3 == 0) ? 90 : 12));
      build_sp(8'($urandom), $urandom % 4, n, lens, $urandom % 8,
               ($urandom % 6 == 0 && n <= MAX_SUB && lens[n-1] > 2) ? 1 + ($urandom % (lens[n-1] - 1)) : 0,
               "R4");
      if ($urandom % 4 == 0) junk(1 + $urandom % 2);
    end
    run(150000);
    if (idx_in < n_ib || idx_out < n_ex) begin
      watchdog_hit = 1;
      chk(0, "watchdog R4", DW'(idx_out), DW'(n_ex));
    end

    // no further output after the last expected beat
    in_valid = 0;
    out_ready = 1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      #1;
      chk(!v0 && !v1 && !v2, "R12 idle", DW'(v0), '0);
    end
    chk(idx_out == n_ex, "R5 beat count", DW'(idx_out), DW'(n_ex));
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule